// File: doc/BRIEF.md
# Serial Bridge Vendor Request Decoder

This block sits behind the control endpoint of a USB-to-serial bridge. It receives each decoded setup record, made up of the request type, the request code and the payload length. It then takes the payload bytes that follow and turns the vendor requests into writes to a small register file. That register file drives the serial engine: the baud divisor, the line control byte, the modem control byte and a flag that holds transmission back until the far end asserts CTS. Read requests return one byte on a response output. A request that the block does not recognise is refused with a one-cycle stall pulse.

The block also watches the modem status byte and the line status byte that the serial engine reports. When either byte differs from the values last sent, it raises a two-byte report for the status interrupt endpoint. Byte 0 of the report carries modem status and byte 1 carries line status. Packet framing, descriptors and the serial shifter itself live elsewhere.

Top module: `serial_ctl_decoder`

## Requirements
- R1: After reset, baudDivisor, lineCtrl, ctsGate, stall, respValid and reportValid are all zero, and modemCtrl is 0x08.
- R2: A setup record with type 0x40, code 5 and length 4 is followed by four payload bytes. The first byte is the least significant byte of baudDivisor. baudDivisor takes the new value at the clock edge that samples the fourth byte.
- R3: Type 0x40, code 7, length 1 writes the payload byte into lineCtrl. Type 0xC0, code 6, length 1 returns lineCtrl on respByte, with respValid high for exactly the one cycle after the setup edge.
- R4: Type 0x40, code 10, length 1 writes the payload byte into modemCtrl.
- R5: Type 0x40, code 12, length 1 sets ctsGate to bit 0 of the payload byte. A value of 1 means hold transmission until CTS; a value of 0 means send freely.
- R6: Type 0x40, code 11, length 1 consumes its single payload byte and changes no register.
- R7: Type 0xC0, code 2, length 1 returns the current modemStatusIn on respByte, with respValid high for the one cycle after the setup edge.
- R8: Any other combination of type, code and length gives a stall pulse in the cycle after the setup edge. It changes no register and consumes no payload byte.
- R9: While payload bytes are being collected, setupValid is ignored. While no payload is expected, dataValid is ignored.
- R10: When modemStatusIn or lineStatusIn differs from the last reported pair (zero after reset), reportValid is high for one cycle, starting one cycle later. reportWord[7:0] then holds the modem status and reportWord[15:8] holds the line status. No report is raised while both bytes stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setupValid | input | 1 | A setup record is present this cycle |
| reqType | input | 8 | Request type (0x40 write, 0xC0 read) |
| reqCode | input | 8 | Vendor request code |
| reqLen | input | 16 | Payload length in bytes |
| dataValid | input | 1 | A payload byte is present this cycle |
| dataByte | input | 8 | Payload byte |
| modemStatusIn | input | 8 | Modem status byte from the serial engine |
| lineStatusIn | input | 8 | Line status byte from the serial engine |
| baudDivisor | output | 32 | Baud divisor register |
| lineCtrl | output | 8 | Line control register |
| modemCtrl | output | 8 | Modem control register |
| ctsGate | output | 1 | Hold transmission until CTS is asserted |
| respValid | output | 1 | Read response is present |
| respByte | output | 8 | Read response byte |
| stall | output | 1 | Request refused |
| reportValid | output | 1 | Status report is present |
| reportWord | output | 16 | Status report: [7:0] modem status, [15:8] line status |

## Verification
A control state stuck in payload collection shows at the ports on the next setup record. A read then returns no respValid, and a malformed request returns no stall, in the cycle after the setup edge. A wrong byte index shows as a scrambled baudDivisor as soon as the fourth byte has been sampled. A stale last-reported status shows either as a missing reportValid one cycle after a status change, or as repeated reports while the inputs stay still. The bench therefore follows every register write with a readback or a port compare before it sends the next request.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;

  localparam logic [7:0] TYPE_HOST_WR = 8'h40;
  localparam logic [7:0] TYPE_HOST_RD = 8'hC0;

  localparam logic [7:0] CODE_RD_MODEM   = 8'd2;
  localparam logic [7:0] CODE_WR_BAUD    = 8'd5;
  localparam logic [7:0] CODE_RD_LINE    = 8'd6;
  localparam logic [7:0] CODE_WR_LINE    = 8'd7;
  localparam logic [7:0] CODE_WR_MODEM   = 8'd10;
  localparam logic [7:0] CODE_WR_AUX     = 8'd11;
  localparam logic [7:0] CODE_WR_CTSGATE = 8'd12;

  localparam int IDX_W = 3;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_BAUD,
    TGT_LINE,
    TGT_MODEM,
    TGT_CTS
  } target_e;

  typedef struct packed {
    logic             capByte;
    logic             commit;
    target_e          target;
    logic [IDX_W-1:0] byteIdx;
    logic             rdLine;
    logic             rdModem;
    logic             stall;
  } strobe_t;

endpackage

// File: rtl/serial_ctl_fsm.sv
module serial_ctl_fsm
  import serial_ctl_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int DIV_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setupValid,
  input  logic [7:0]       reqType,
  input  logic [7:0]       reqCode,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             dataValid,
  output strobe_t          strb
);

  typedef enum logic {ST_IDLE, ST_COLLECT} state_e;

  state_e           state;
  target_e          tgtQ;
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] lastIdxQ;

  logic             decOk;
  logic             decRead;
  target_e          decTgt;
  logic [IDX_W-1:0] decLast;
  logic             lenOne;
  logic             lenDiv;

  assign lenOne = (reqLen == LEN_W'(1));
  assign lenDiv = (reqLen == LEN_W'(DIV_BYTES));

  always_comb begin
    decOk   = 1'b0;
    decRead = 1'b0;
    decTgt  = TGT_NONE;
    decLast = '0;
    if (reqType == TYPE_HOST_WR) begin
      unique case (reqCode)
        CODE_WR_BAUD: begin
          decOk   = lenDiv;
          decTgt  = TGT_BAUD;
          decLast = IDX_W'(DIV_BYTES - 1);
        end
        CODE_WR_LINE:    begin decOk = lenOne; decTgt = TGT_LINE;  end
        CODE_WR_MODEM:   begin decOk = lenOne; decTgt = TGT_MODEM; end
        CODE_WR_CTSGATE: begin decOk = lenOne; decTgt = TGT_CTS;   end
        CODE_WR_AUX:     begin decOk = lenOne; decTgt = TGT_NONE;  end
        default:         decOk = 1'b0;
      endcase
    end else if (reqType == TYPE_HOST_RD) begin
      decRead = 1'b1;
      unique case (reqCode)
        CODE_RD_LINE:  decOk = lenOne;
        CODE_RD_MODEM: decOk = lenOne;
        default:       decOk = 1'b0;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    if (state == ST_IDLE && setupValid) begin
      if (!decOk) begin
        strb.stall = 1'b1;
      end else if (decRead) begin
        strb.rdLine  = (reqCode == CODE_RD_LINE);
        strb.rdModem = (reqCode == CODE_RD_MODEM);
      end
    end
    if (state == ST_COLLECT && dataValid) begin
      strb.capByte = 1'b1;
      strb.byteIdx = idxQ;
      strb.target  = tgtQ;
      strb.commit  = (idxQ == lastIdxQ);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tgtQ     <= TGT_NONE;
      idxQ     <= '0;
      lastIdxQ <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (setupValid && decOk && !decRead) begin
            state    <= ST_COLLECT;
            tgtQ     <= decTgt;
            lastIdxQ <= decLast;
            idxQ     <= '0;
          end
        end
        ST_COLLECT: begin
          if (dataValid) begin
            if (idxQ == lastIdxQ) begin
              state <= ST_IDLE;
              idxQ  <= '0;
            end else begin
              idxQ <= idxQ + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
  import serial_ctl_pkg::*;
#(
  parameter int         DIV_BYTES = 4,
  parameter logic [7:0] MODEM_RST = 8'h08
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [7:0]             dataByte,
  input  logic [7:0]             modemStatusIn,
  input  logic [7:0]             lineStatusIn,
  output logic [DIV_BYTES*8-1:0] baudDivisor,
  output logic [7:0]             lineCtrl,
  output logic [7:0]             modemCtrl,
  output logic                   ctsGate,
  output logic                   respValid,
  output logic [7:0]             respByte,
  output logic                   stall,
  output logic                   reportValid,
  output logic [15:0]            reportWord
);

  localparam int IDX_BITS = (DIV_BYTES > 1) ? $clog2(DIV_BYTES) : 1;

  logic [DIV_BYTES-1:0][7:0] accQ;
  logic [DIV_BYTES-1:0][7:0] assembled;
  logic [IDX_BITS-1:0]       idx;
  logic [7:0]                lastModem;
  logic [7:0]                lastLine;
  logic                      statusMoved;

  assign idx = strb.byteIdx[IDX_BITS-1:0];

  // Byte lanes of the divisor: the lane selected by the current byte index
  // takes the incoming byte, the others take what was already collected.
  for (genvar g = 0; g < DIV_BYTES; g++) begin : g_lane
    assign assembled[g] = (strb.capByte && idx == IDX_BITS'(g)) ? dataByte : accQ[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        accQ[g] <= '0;
      end else if (strb.capByte && idx == IDX_BITS'(g)) begin
        accQ[g] <= dataByte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baudDivisor <= '0;
      lineCtrl    <= '0;
      modemCtrl   <= MODEM_RST;
      ctsGate     <= 1'b0;
    end else if (strb.commit) begin
      unique case (strb.target)
        TGT_BAUD:  baudDivisor <= assembled;
        TGT_LINE:  lineCtrl    <= dataByte;
        TGT_MODEM: modemCtrl   <= dataByte;
        TGT_CTS:   ctsGate     <= dataByte[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respByte  <= '0;
      stall     <= 1'b0;
    end else begin
      respValid <= strb.rdLine | strb.rdModem;
      stall     <= strb.stall;
      if (strb.rdLine) begin
        respByte <= lineCtrl;
      end else if (strb.rdModem) begin
        respByte <= modemStatusIn;
      end
    end
  end

  assign statusMoved = (modemStatusIn != lastModem) || (lineStatusIn != lastLine);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastModem   <= '0;
      lastLine    <= '0;
      reportValid <= 1'b0;
      reportWord  <= '0;
    end else begin
      reportValid <= statusMoved;
      if (statusMoved) begin
        lastModem  <= modemStatusIn;
        lastLine   <= lineStatusIn;
        reportWord <= {lineStatusIn, modemStatusIn};
      end
    end
  end

endmodule

// File: rtl/serial_ctl_decoder.sv
module serial_ctl_decoder
  import serial_ctl_pkg::*;
#(
  parameter int         LEN_W     = 16,
  parameter int         DIV_BYTES = 4,
  parameter logic [7:0] MODEM_RST = 8'h08
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   setupValid,
  input  logic [7:0]             reqType,
  input  logic [7:0]             reqCode,
  input  logic [LEN_W-1:0]       reqLen,
  input  logic                   dataValid,
  input  logic [7:0]             dataByte,
  input  logic [7:0]             modemStatusIn,
  input  logic [7:0]             lineStatusIn,
  output logic [DIV_BYTES*8-1:0] baudDivisor,
  output logic [7:0]             lineCtrl,
  output logic [7:0]             modemCtrl,
  output logic                   ctsGate,
  output logic                   respValid,
  output logic [7:0]             respByte,
  output logic                   stall,
  output logic                   reportValid,
  output logic [15:0]            reportWord
);

  strobe_t strb;

  serial_ctl_fsm #(
    .LEN_W    (LEN_W),
    .DIV_BYTES(DIV_BYTES)
  ) u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .setupValid(setupValid),
    .reqType   (reqType),
    .reqCode   (reqCode),
    .reqLen    (reqLen),
    .dataValid (dataValid),
    .strb      (strb)
  );

  serial_ctl_regs #(
    .DIV_BYTES(DIV_BYTES),
    .MODEM_RST(MODEM_RST)
  ) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .dataByte     (dataByte),
    .modemStatusIn(modemStatusIn),
    .lineStatusIn (lineStatusIn),
    .baudDivisor  (baudDivisor),
    .lineCtrl     (lineCtrl),
    .modemCtrl    (modemCtrl),
    .ctsGate      (ctsGate),
    .respValid    (respValid),
    .respByte     (respByte),
    .stall        (stall),
    .reportValid  (reportValid),
    .reportWord   (reportWord)
  );

endmodule

// File: rtl/serial_ctl_checker.sv
module serial_ctl_checker
  import serial_ctl_pkg::*;
#(
  parameter int DIV_BYTES = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input strobe_t                strb,
  input logic [DIV_BYTES*8-1:0] baudDivisor,
  input logic [7:0]             lineCtrl,
  input logic [7:0]             modemCtrl,
  input logic                   ctsGate,
  input logic                   respValid,
  input logic                   stall,
  input logic                   reportValid,
  input logic [15:0]            reportWord
);

  // R8: a refused request leaves every register as it was
  assert_stall_keeps_regs_R8: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> ($stable(baudDivisor) && $stable(lineCtrl) && $stable(modemCtrl) && $stable(ctsGate)));

  // R3, R7, R8: a request either answers or stalls, never both
  assert_resp_or_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({respValid, stall}));

  // R2: the divisor moves only after a commit that targets it
  assert_baud_only_on_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(baudDivisor) |-> $past(strb.commit && strb.target == TGT_BAUD));

  // R5: the CTS gate moves only after a commit that targets it
  assert_cts_only_on_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctsGate) |-> $past(strb.commit && strb.target == TGT_CTS));

  // R6: the auxiliary request commits with no register change
  assert_aux_no_effect_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && strb.target == TGT_NONE) |=>
      ($stable(baudDivisor) && $stable(lineCtrl) && $stable(modemCtrl) && $stable(ctsGate)));

  // R10: back-to-back reports must carry differing contents
  assert_report_changes_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reportValid && $past(reportValid)) |-> (reportWord != $past(reportWord)));

endmodule

bind serial_ctl_decoder serial_ctl_checker #(.DIV_BYTES(DIV_BYTES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .strb       (strb),
  .baudDivisor(baudDivisor),
  .lineCtrl   (lineCtrl),
  .modemCtrl  (modemCtrl),
  .ctsGate    (ctsGate),
  .respValid  (respValid),
  .stall      (stall),
  .reportValid(reportValid),
  .reportWord (reportWord)
);

// File: tb/serial_ctl_decoder_bench.sv
module serial_ctl_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setupValid = 1'b0;
  logic [7:0]  reqType = '0;
  logic [7:0]  reqCode = '0;
  logic [15:0] reqLen = '0;
  logic        dataValid = 1'b0;
  logic [7:0]  dataByte = '0;
  logic [7:0]  modemStatusIn = '0;
  logic [7:0]  lineStatusIn = '0;
  logic [31:0] baudDivisor;
  logic [7:0]  lineCtrl;
  logic [7:0]  modemCtrl;
  logic        ctsGate;
  logic        respValid;
  logic [7:0]  respByte;
  logic        stall;
  logic        reportValid;
  logic [15:0] reportWord;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] expBaud;
  logic [7:0]  expLine;
  logic [7:0]  expModem;
  logic        expCts;

  always #2.5 clk = ~clk;

  serial_ctl_decoder u_serial_ctl_decoder (
    .clk(clk), .rstN(rstN), .setupValid(setupValid), .reqType(reqType),
    .reqCode(reqCode), .reqLen(reqLen), .dataValid(dataValid), .dataByte(dataByte),
    .modemStatusIn(modemStatusIn), .lineStatusIn(lineStatusIn),
    .baudDivisor(baudDivisor), .lineCtrl(lineCtrl), .modemCtrl(modemCtrl),
    .ctsGate(ctsGate), .respValid(respValid), .respByte(respByte), .stall(stall),
    .reportValid(reportValid), .reportWord(reportWord)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Expected acceptance of a request, from the requirement table
  function automatic bit isLegal(input logic [7:0] t, input logic [7:0] c, input logic [15:0] l);
    if (t == 8'h40)
      return (c == 8'd5 && l == 16'd4) ||
             ((c == 8'd7 || c == 8'd10 || c == 8'd11 || c == 8'd12) && l == 16'd1);
    if (t == 8'hC0)
      return (c == 8'd6 || c == 8'd2) && l == 16'd1;
    return 1'b0;
  endfunction

  task automatic doSetup(input logic [7:0] t, input logic [7:0] c, input logic [15:0] l);
    @(negedge clk);
    setupValid = 1'b1; reqType = t; reqCode = c; reqLen = l;
    @(negedge clk);
    setupValid = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    dataValid = 1'b1; dataByte = b;
    @(negedge clk);
    dataValid = 1'b0;
  endtask

  task automatic checkRegs(input string tag);
    check({tag, " baud"}, baudDivisor, expBaud);
    check({tag, " line"}, 32'(lineCtrl), 32'(expLine));
    check({tag, " modem"}, 32'(modemCtrl), 32'(expModem));
    check({tag, " cts"}, 32'(ctsGate), 32'(expCts));
  endtask

  task automatic writeBaud(input logic [31:0] v);
    doSetup(8'h40, 8'd5, 16'd4);
    for (int i = 0; i < 4; i++) sendByte(v[i*8 +: 8]);
    expBaud = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    expBaud = '0; expLine = '0; expModem = 8'h08; expCts = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkRegs("R1 reset");
    check("R1 stall", 32'(stall), 0);
    check("R1 respValid", 32'(respValid), 0);
    check("R1 reportValid", 32'(reportValid), 0);

    // R2 directed divisor, byte order: 115200/9600 = 12 with upper bytes set
    writeBaud(32'hA1B2_000C);
    check("R2 baud directed", baudDivisor, 32'hA1B2_000C);
    // R2 divisor not yet committed after three bytes
    doSetup(8'h40, 8'd5, 16'd4);
    for (int i = 0; i < 3; i++) sendByte(8'h11 * 8'(i + 1));
    check("R2 baud before fourth byte", baudDivisor, 32'hA1B2_000C);
    sendByte(8'h44);
    expBaud = 32'h4433_2211;
    check("R2 baud after fourth byte", baudDivisor, expBaud);

    // R3 line write and readback
    doSetup(8'h40, 8'd7, 16'd1); sendByte(8'h1B); expLine = 8'h1B;
    check("R3 line write", 32'(lineCtrl), 32'h1B);
    doSetup(8'hC0, 8'd6, 16'd1);
    check("R3 read valid", 32'(respValid), 1);
    check("R3 read byte", 32'(respByte), 32'h1B);
    @(negedge clk);
    check("R3 read valid drops", 32'(respValid), 0);

    // R4 modem control values
    doSetup(8'h40, 8'd10, 16'd1); sendByte(8'h09); expModem = 8'h09;
    check("R4 modem dtr", 32'(modemCtrl), 32'h09);
    doSetup(8'h40, 8'd10, 16'd1); sendByte(8'h0A); expModem = 8'h0A;
    check("R4 modem rts", 32'(modemCtrl), 32'h0A);

    // R5 CTS gate on and off
    doSetup(8'h40, 8'd12, 16'd1); sendByte(8'h01); expCts = 1'b1;
    check("R5 cts on", 32'(ctsGate), 1);
    doSetup(8'h40, 8'd12, 16'd1); sendByte(8'h00); expCts = 1'b0;
    check("R5 cts off", 32'(ctsGate), 0);

    // R6 auxiliary request: no effect, and the next request is accepted normally
    doSetup(8'h40, 8'd11, 16'd1); sendByte(8'hFF);
    checkRegs("R6 aux");
    doSetup(8'hC0, 8'd6, 16'd1);
    check("R6 idle after aux", 32'(respValid), 1);

    // R7 modem status read
    modemStatusIn = 8'hB0;
    doSetup(8'hC0, 8'd2, 16'd1);
    check("R7 msr valid", 32'(respValid), 1);
    check("R7 msr byte", 32'(respByte), 32'hB0);
    modemStatusIn = 8'h00;
    repeat (3) @(negedge clk);

    // R8 directed refusals: length mismatch and unknown code
    doSetup(8'h40, 8'd7, 16'd2);
    check("R8 bad length stall", 32'(stall), 1);
    sendByte(8'h77);
    checkRegs("R8 bad length");
    doSetup(8'h40, 8'd3, 16'd1);
    check("R8 unknown code stall", 32'(stall), 1);
    @(negedge clk);
    check("R8 stall drops", 32'(stall), 0);

    // R9 setup ignored mid-payload, data ignored while idle
    doSetup(8'h40, 8'd5, 16'd4);
    sendByte(8'h01); sendByte(8'h02);
    doSetup(8'h40, 8'd7, 16'd1);
    sendByte(8'h03); sendByte(8'h04);
    expBaud = 32'h0403_0201;
    check("R9 baud intact", baudDivisor, expBaud);
    check("R9 line untouched", 32'(lineCtrl), 32'(expLine));
    sendByte(8'h5A);
    checkRegs("R9 idle data");

    // R10 status report
    modemStatusIn = 8'h31; lineStatusIn = 8'h60;
    @(negedge clk);
    check("R10 report valid", 32'(reportValid), 1);
    check("R10 report word", 32'(reportWord), 32'h6031);
    @(negedge clk);
    check("R10 no repeat", 32'(reportValid), 0);
    lineStatusIn = 8'h61;
    @(negedge clk);
    check("R10 line only", 32'(reportWord), 32'h6131);
    check("R10 line only valid", 32'(reportValid), 1);

    // Random mix
    for (int n = 0; n < 200; n++) begin
      int sel = $urandom_range(0, 5);
      logic [7:0] b = 8'($urandom);
      case (sel)
        0: begin writeBaud($urandom); check("R2 random baud", baudDivisor, expBaud); end
        1: begin
          doSetup(8'h40, 8'd7, 16'd1); sendByte(b); expLine = b;
          doSetup(8'hC0, 8'd6, 16'd1);
          check("R3 random readback", 32'(respByte), 32'(b));
        end
        2: begin
          doSetup(8'h40, 8'd10, 16'd1); sendByte(b); expModem = b;
          check("R4 random modem", 32'(modemCtrl), 32'(b));
        end
        3: begin
          doSetup(8'h40, 8'd12, 16'd1); sendByte(b); expCts = b[0];
          check("R5 random cts", 32'(ctsGate), 32'(b[0]));
        end
        4: begin
          logic [7:0] t = ($urandom_range(0, 2) == 0) ? 8'($urandom) : (b[0] ? 8'h40 : 8'hC0);
          logic [7:0] c = 8'($urandom_range(0, 15));
          logic [15:0] l = 16'($urandom_range(0, 5));
          if (!isLegal(t, c, l)) begin
            doSetup(t, c, l);
            check("R8 random stall", 32'(stall), 1);
            checkRegs("R8 random");
          end
        end
        default: begin
          logic [7:0] m = 8'($urandom);
          logic [7:0] ls = 8'($urandom);
          logic chg = (m != modemStatusIn) || (ls != lineStatusIn);
          modemStatusIn = m; lineStatusIn = ls;
          @(negedge clk);
          check("R10 random valid", 32'(reportValid), 32'(chg));
          if (chg) check("R10 random word", 32'(reportWord), 32'({ls, m}));
          @(negedge clk);
          check("R10 random settle", 32'(reportValid), 0);
        end
      endcase
    end
    checkRegs("final");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule